// File: doc/BRIEF.md
# Fixed-Frame Buffered SPI Slave

This block is an SPI slave that exchanges whole frames of a fixed byte count with an external master. The count is set once, when the block is configured. The master decides when a frame starts, how fast it is clocked and how long the gaps between bytes are. The block therefore shifts every byte from its own buffers, and the host does nothing between bytes. The host acts only at frame boundaries: it reads the received frame through a random-access read port, acknowledges the frame-complete interrupt, and queues the next outgoing frame one byte at a time.

Transmit storage is two banks. One bank is being shifted out. The other is the pending frame that the host fills. When a frame completes with the pending frame full, the two banks swap roles. Right after configuration the outgoing frame is all zeros, and the same happens after any frame that completes with nothing queued. Receive storage is also two banks. Bytes are written into the hidden bank, and only a complete frame flips that bank into view. A frame that the master aborts therefore never disturbs the frame the host is reading.

The SPI inputs are sampled by the system clock through two-stage synchronizers, so the SPI clock must run well below the system clock. Eight or more system cycles per SPI clock phase is the intended range.

Top module: `fss_slave`

## Requirements
- R1: A configuration write with a length from 1 to MAXB sets cfg_ok. A length of 0 or above MAXB clears cfg_ok, and then no SPI activity raises irq. Any configuration write clears irq, underrun and overrun, and empties the pending frame (tx_ready is 1 only while cfg_ok is 1 and the pending frame is not full).
- R2: The first frame after a configuration write returns zero bytes on miso.
- R3: All four SPI modes work. The cpol input is the idle level of sclk. With cpha 0, data is sampled on the leading (first) sclk edge and miso changes on the trailing edge. With cpha 1, data is sampled on the trailing edge and miso changes on the leading edge. Bytes go most significant bit first in both directions.
- R4: After a complete frame, the byte received k-th (k from 0) is read on rx_data when rx_addr is k.
- R5: irq rises once the programmed number of bytes has been exchanged with cs_n low, and it stays high until a cycle with irq_ack high.
- R6: The host queues a frame by writing len bytes on tx_data with tx_valid, in send order. tx_ready falls after the len-th byte. The queued frame is sent in the frame after the one that was active when it was queued.
- R7: When a frame completes with a full pending frame, the pending frame becomes the active one and tx_ready returns to 1.
- R8: While tx_ready is 0, writes are ignored: a queued frame is sent unchanged.
- R9: When a frame completes with no full pending frame, the next frame returns zero bytes and the sticky underrun output is set.
- R10: Raising cs_n before len bytes have been exchanged discards the partial frame. No irq is raised, the readable receive frame is unchanged, the pending frame is kept, and the next frame starts again at byte 0.
- R11: A frame that completes while irq is still high and unacknowledged sets the sticky overrun output, and the newest frame replaces the readable receive frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_len | input | LW | Requested frame length in bytes |
| cfg_cpol | input | 1 | Clock polarity (idle level of sclk) |
| cfg_cpha | input | 1 | Clock phase (1 = sample on trailing edge) |
| cfg_ok | output | 1 | Last configuration was accepted |
| tx_valid | input | 1 | Host byte write into the pending frame |
| tx_data | input | 8 | Byte for the pending frame |
| tx_ready | output | 1 | Pending frame can accept bytes |
| irq | output | 1 | Frame-complete interrupt, level |
| irq_ack | input | 1 | Clears irq |
| rx_addr | input | AW | Byte index into the received frame |
| rx_data | output | 8 | Received byte at rx_addr |
| underrun | output | 1 | Sticky: a frame completed with nothing queued |
| overrun | output | 1 | Sticky: a frame completed before irq was acknowledged |
| sclk | input | 1 | SPI clock from the master |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI data from the master |
| miso | output | 1 | SPI data to the master |

## Verification
A wrong byte counter shows within one frame: irq rises early or late, or the received bytes appear at shifted addresses on the read port. A wrong bank select or a stale pending flag shows at the next frame, as miso bytes that differ from the queued frame or as zeros where data was expected. tx_ready and underrun also show it in the cycles right after completion. An edge-select error for a given mode corrupts the very first byte, which arrives bit-shifted on both miso and the receive buffer.

// File: rtl/fss_slave.sv
`timescale 1ns/1ps
module fss_slave #(
  parameter int MAXB = 16,
  parameter int LW   = $clog2(MAXB + 1),
  parameter int AW   = $clog2(MAXB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [LW-1:0] cfg_len,
  input  logic          cfg_cpol,
  input  logic          cfg_cpha,
  output logic          cfg_ok,
  input  logic          tx_valid,
  input  logic [7:0]    tx_data,
  output logic          tx_ready,
  output logic          irq,
  input  logic          irq_ack,
  input  logic [AW-1:0] rx_addr,
  output logic [7:0]    rx_data,
  output logic          underrun,
  output logic          overrun,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          mosi,
  output logic          miso
);

  logic [2:0]    sck_q, cs_q;
  logic [1:0]    mo_q;
  logic [LW-1:0] len, wr_cnt, bcnt;
  logic          cpol, cpha, act, zero_act, pend_full, rxb;
  logic [2:0]    bc;
  logic [6:0]    rsh;
  logic [7:0]    cur, nxt;
  logic [7:0]    txm [2][MAXB];
  logic [7:0]    rxm [2][MAXB];

  wire sck_r   = sck_q[1] & ~sck_q[2];
  wire sck_f   = ~sck_q[1] & sck_q[2];
  wire lead    = cpol ? sck_f : sck_r;
  wire trail   = cpol ? sck_r : sck_f;
  wire sel     = cfg_ok & ~cs_q[1];
  wire smp     = sel & (cpha ? trail : lead);
  wire drv     = sel & (cpha ? lead : trail);
  wire cs_fall = cfg_ok & cs_q[2] & ~cs_q[1];
  wire cs_rise = ~cs_q[2] & cs_q[1];
  wire byte_end = smp && (bc == 3'd7);
  wire fdone   = byte_end && (bcnt == len - 1'b1);
  wire wr_acc  = tx_valid & tx_ready;
  wire len_ok  = (cfg_len != '0) && (cfg_len <= LW'(MAXB));

  assign tx_ready = cfg_ok & ~pend_full;
  assign rx_data  = rxm[rxb][rx_addr];
  assign miso     = cur[7];

  always_comb begin
    nxt = 8'h00;
    if (!zero_act && bcnt < len) nxt = txm[act][bcnt[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (wr_acc) txm[~act][wr_cnt[AW-1:0]] <= tx_data;
  end

  always_ff @(posedge clk) begin
    if (!cfg_we && byte_end) rxm[~rxb][bcnt[AW-1:0]] <= {rsh, mo_q[1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      cs_q  <= '1;
      mo_q  <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sclk};
      cs_q  <= {cs_q[1:0], cs_n};
      mo_q  <= {mo_q[0], mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_ok    <= 1'b0;
      len       <= '0;
      cpol      <= 1'b0;
      cpha      <= 1'b0;
      act       <= 1'b0;
      zero_act  <= 1'b1;
      pend_full <= 1'b0;
      wr_cnt    <= '0;
      bcnt      <= '0;
      bc        <= '0;
      rsh       <= '0;
      cur       <= '0;
      rxb       <= 1'b0;
      irq       <= 1'b0;
      underrun  <= 1'b0;
      overrun   <= 1'b0;
    end else if (cfg_we) begin
      cfg_ok    <= len_ok;
      if (len_ok) begin
        len  <= cfg_len;
        cpol <= cfg_cpol;
        cpha <= cfg_cpha;
      end
      zero_act  <= 1'b1;
      pend_full <= 1'b0;
      wr_cnt    <= '0;
      bcnt      <= '0;
      bc        <= '0;
      cur       <= '0;
      irq       <= 1'b0;
      underrun  <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (wr_acc) begin
        if (wr_cnt == len - 1'b1) begin
          wr_cnt    <= '0;
          pend_full <= 1'b1;
        end else begin
          wr_cnt <= wr_cnt + 1'b1;
        end
      end

      if (cs_fall) begin
        bc   <= '0;
        bcnt <= '0;
        cur  <= nxt;
      end
      if (cs_rise) begin
        bc   <= '0;
        bcnt <= '0;
      end

      if (smp) begin
        rsh <= {rsh[5:0], mo_q[1]};
        bc  <= bc + 1'b1;
        if (byte_end) bcnt <= fdone ? '0 : bcnt + 1'b1;
      end
      if (drv) cur <= (bc == 3'd0) ? nxt : {cur[6:0], 1'b0};

      if (fdone) begin
        rxb <= ~rxb;
        irq <= 1'b1;
        if (irq && !irq_ack) overrun <= 1'b1;
        if (pend_full) begin
          act       <= ~act;
          zero_act  <= 1'b0;
          pend_full <= 1'b0;
        end else begin
          zero_act <= 1'b1;
          underrun <= 1'b1;
        end
      end else if (irq_ack) begin
        irq <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/fss_slave_chk.sv
`timescale 1ns/1ps
module fss_slave_chk #(
  parameter int MAXB = 16,
  parameter int LW   = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [LW-1:0] cfg_len,
  input logic          cfg_ok,
  input logic          irq,
  input logic          irq_ack,
  input logic          tx_ready,
  input logic          underrun,
  input logic          overrun,
  input logic          fdone,
  input logic          pend_full
);

  AST_REJECT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && (cfg_len == '0 || cfg_len > LW'(MAXB)) |=> !cfg_ok); // R1

  AST_UNCFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ok |-> !irq); // R1

  AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fdone && !cfg_we |=> irq); // R5

  AST_IRQ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    irq && irq_ack && !fdone && !cfg_we |=> !irq); // R5

  AST_PEND_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    fdone && pend_full && !cfg_we |=> tx_ready); // R7

  AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    fdone && !pend_full && !cfg_we |=> underrun); // R9

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    fdone && irq && !irq_ack && !cfg_we |=> overrun); // R11

endmodule

bind fss_slave fss_slave_chk #(.MAXB(MAXB), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_len(cfg_len),
  .cfg_ok(cfg_ok), .irq(irq), .irq_ack(irq_ack), .tx_ready(tx_ready),
  .underrun(underrun), .overrun(overrun), .fdone(fdone), .pend_full(pend_full)
);

// File: tb/fss_slave_bench.sv
`timescale 1ns/1ps
module fss_slave_bench;
  localparam int MAXB = 16;
  localparam int LW   = $clog2(MAXB + 1);
  localparam int AW   = $clog2(MAXB);
  localparam int H    = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic [LW-1:0] cfg_len = '0;
  logic cfg_ok, tx_ready, irq, underrun, overrun, miso;
  logic tx_valid = 1'b0, irq_ack = 1'b0;
  logic [7:0] tx_data = '0, rx_data;
  logic [AW-1:0] rx_addr = '0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;

  int vecs = 0, errs = 0;
  bit done = 1'b0;
  bit cpol_m = 1'b0, cpha_m = 1'b0;
  logic [7:0] got_byte;
  logic [7:0] exp_q [$];
  string tag_q [$];
  event byte_ev;

  always #2.5 clk = ~clk;

  fss_slave #(.MAXB(MAXB)) u_fss_slave (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_len(cfg_len),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_ok(cfg_ok),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .irq(irq), .irq_ack(irq_ack), .rx_addr(rx_addr), .rx_data(rx_data),
    .underrun(underrun), .overrun(overrun),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  task automatic chk(input bit ok, input string r, input int actv, input int expv);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", r, actv, expv);
    end
  endtask

  always @(byte_ev) begin
    if (exp_q.size() == 0) begin
      chk(1'b0, "miso-queue-empty", int'(got_byte), 0);
    end else begin
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(got_byte === e, t, int'(got_byte), int'(e));
    end
  end

  task automatic expect_frame(input logic [31:0] d, input int nb, input string t);
    for (int k = 0; k < nb; k++) begin
      exp_q.push_back(d[31-8*k -: 8]);
      tag_q.push_back(t);
    end
  endtask

  task automatic configure(input int l, input bit pol, input bit pha);
    sclk = pol;
    repeat (4) @(negedge clk);
    cfg_we = 1'b1; cfg_len = LW'(l); cfg_cpol = pol; cfg_cpha = pha;
    @(negedge clk);
    cfg_we = 1'b0;
    cpol_m = pol; cpha_m = pha;
    @(negedge clk); #1;
  endtask

  task automatic push_tx(input logic [31:0] d);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      tx_valid = 1'b1; tx_data = d[31-8*k -: 8];
    end
    @(negedge clk);
    tx_valid = 1'b0;
    #1;
  endtask

  task automatic frame(input logic [31:0] mo, input int nb);
    logic [7:0] b, g;
    cs_n = 1'b0;
    #H;
    for (int k = 0; k < nb; k++) begin
      b = mo[31-8*k -: 8];
      g = '0;
      for (int i = 0; i < 8; i++) begin
        if (!cpha_m) begin
          mosi = b[7-i];
          #H; sclk = ~cpol_m; g = {g[6:0], miso};
          #H; sclk = cpol_m;
        end else begin
          sclk = ~cpol_m; mosi = b[7-i];
          #H; sclk = cpol_m; g = {g[6:0], miso};
          #H;
        end
      end
      got_byte = g;
      ->byte_ev;
    end
    #H; cs_n = 1'b1;
    #(4*H);
  endtask

  task automatic rx_check(input logic [31:0] e, input string t);
    for (int a = 0; a < 4; a++) begin
      @(negedge clk);
      rx_addr = AW'(a);
      #1;
      chk(rx_data === e[31-8*a -: 8], t, int'(rx_data), int'(e[31-8*a -: 8]));
    end
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    #1;
  endtask

  initial begin
    #900_000;
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(cfg_ok == 1'b0, "R1 reset cfg_ok", cfg_ok, 0);
    chk(irq == 1'b0, "R1 reset irq", irq, 0);
    chk(tx_ready == 1'b0, "R1 reset tx_ready", tx_ready, 0);

    configure(20, 1'b0, 1'b0);
    chk(cfg_ok == 1'b0, "R1 len over max", cfg_ok, 0);
    configure(0, 1'b0, 1'b0);
    chk(cfg_ok == 1'b0, "R1 len zero", cfg_ok, 0);
    expect_frame(32'h0, 4, "R1 unconfigured miso");
    frame(32'hDEAD_BEEF, 4);
    chk(irq == 1'b0, "R1 no irq unconfigured", irq, 0);

    configure(4, 1'b0, 1'b0);
    chk(cfg_ok == 1'b1, "R1 accept", cfg_ok, 1);
    chk(tx_ready == 1'b1, "R1 ready after config", tx_ready, 1);

    push_tx(32'hA1B2_C3D4);
    chk(tx_ready == 1'b0, "R6 ready low when full", tx_ready, 0);
    push_tx(32'h5566_7788);
    chk(tx_ready == 1'b0, "R8 still full", tx_ready, 0);

    expect_frame(32'h0, 4, "R2 zero first frame");
    frame(32'h1357_9BDF, 4);
    chk(irq == 1'b1, "R5 irq raised", irq, 1);
    rx_check(32'h1357_9BDF, "R4 rx frame");
    chk(tx_ready == 1'b1, "R7 pending released", tx_ready, 1);
    chk(underrun == 1'b0, "R9 no underrun", underrun, 0);
    ack();
    chk(irq == 1'b0, "R5 irq acked", irq, 0);

    expect_frame(32'hA1B2_C3D4, 2, "R10 partial bytes");
    frame(32'hFFFF_0000, 2);
    chk(irq == 1'b0, "R10 no irq on abort", irq, 0);
    rx_check(32'h1357_9BDF, "R10 rx kept");

    expect_frame(32'hA1B2_C3D4, 4, "R8 queued frame unchanged R6");
    frame(32'h2468_ACE0, 4);
    chk(irq == 1'b1, "R5 irq frame2", irq, 1);
    rx_check(32'h2468_ACE0, "R10 restart at byte 0");
    chk(underrun == 1'b1, "R9 underrun set", underrun, 1);
    chk(overrun == 1'b0, "R11 no overrun yet", overrun, 0);

    expect_frame(32'h0, 4, "R9 zeros after underrun");
    frame(32'h0F1E_2D3C, 4);
    chk(overrun == 1'b1, "R11 overrun set", overrun, 1);
    rx_check(32'h0F1E_2D3C, "R11 newest frame");

    for (int m = 1; m < 4; m++) begin
      logic [31:0] c;
      c = {8'h80 | 8'(m), 8'h3C, 8'hC3, 8'h01 + 8'(m)};
      configure(4, m[1], m[0]);
      chk(underrun == 1'b0 && overrun == 1'b0, "R1 flags cleared", {underrun, overrun}, 0);
      push_tx(c);
      expect_frame(32'h0, 4, "R2 zero frame mode");
      frame(~c, 4);
      rx_check(~c, "R3 mode rx");
      ack();
      expect_frame(c, 4, "R3 mode miso");
      frame(c ^ 32'h5A5A_5A5A, 4);
      rx_check(c ^ 32'h5A5A_5A5A, "R3 mode rx2");
      ack();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule